// File: doc/BRIEF.md
# Optical Interface Configuration Manager

This block lives inside each optical network interface and applies stored settings to the laser transmitters and the receiver micro-rings. It holds a small table with one entry for each combination of operating mode and step number. An entry gives a power code for every laser, an on/off bit for every ring, the length of the step in clock cycles, and a flag that marks the last step of a sequence.

A shared sequencer drives the block one step at a time. It raises `start` for one cycle and presents a mode. The manager reads the entry for that mode and its current step, drives the laser and ring controls for the programmed number of cycles, and then reports the end of the step with a one-cycle `stepDone` pulse. The lasers stay dark between steps. The step counter advances on its own, wraps at the end of a sequence, and goes back to zero whenever the sequencer selects a different mode.

Top module: `oni_cfg_manager`

## Requirements
- R1: After reset, `laserCtl`, `ringCtl` and `stepDone` are all zero, the step index is 0 and the remembered mode is 0.
- R2: A write with `wrEn` high stores {`wrLaser`, `wrRing`, `wrDur`, `wrLast`} at entry (`wrMode`, `wrStep`). Laser i uses bits [3i+2:3i] of the laser fields. Ring i uses bit i, and 1 means the ring drops its wavelength.
- R3: When `start` is sampled at edge c while the block is idle, `laserCtl` and `ringCtl` show the selected entry from edge c+1.
- R4: The lasers keep the entry's codes for D cycles, where D is the stored duration and a duration of 0 counts as 1. At edge c+1+D `laserCtl` becomes 0, and it stays 0 until the next accepted start. `ringCtl` keeps its value across that edge and between steps.
- R5: `stepDone` is high for exactly the one cycle that follows edge c+1+D.
- R6: After a completed step the step index increases by one. It returns to 0 instead if the entry's last flag is set or if the step was step 7.
- R7: An accepted start whose mode differs from the mode of the previous accepted start uses step 0.
- R8: Laser codes 5, 6 and 7 are driven as 4. Codes 0 to 4 are driven unchanged, where 0 means off and 1 to 4 are power levels.
- R9: `start` is ignored from the edge that accepts it until `stepDone` rises. The ignored start changes neither the outputs nor the step index or mode used next. A start in the cycle where `stepDone` is high is accepted.
- R10: If a write and an accepted start address the same entry in the same cycle, that step uses the old contents. The next read of that entry returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrMode | input | 2 | Mode index of the entry written |
| wrStep | input | 3 | Step index of the entry written |
| wrLaser | input | 24 | Eight 3-bit laser codes |
| wrRing | input | 8 | Ring drop mask |
| wrDur | input | 16 | Step length in cycles |
| wrLast | input | 1 | Last-step flag |
| start | input | 1 | Sequencer command to begin the current step |
| mode | input | 2 | Mode selected by the sequencer |
| stepDone | output | 1 | One-cycle end-of-step pulse |
| laserCtl | output | 24 | Applied laser codes |
| ringCtl | output | 8 | Applied ring mask |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a table write and the read of the same entry by an accepted start. The bench drives both in one cycle with new laser and ring values. It expects the step to show the old values and the next visit to that entry to show the new ones.

The second pair is the end of one step and the acceptance of the next. The bench raises `start` while `stepDone` is high. Its scoreboard then expects the following entry to appear exactly one edge later, with no gap and no lost pulse.

// File: rtl/oni_cfg_pkg.sv
`timescale 1ns/1ps
package oni_cfg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_RUN
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOut;
    logic countDown;
    logic endStep;
  } strobe_t;

endpackage

// File: rtl/oni_cfg_mem.sv
`timescale 1ns/1ps
module oni_cfg_mem #(
  parameter int ENTRY_W = 49,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [ENTRY_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENTRY_W-1:0] store [DEPTH];

  // Registered read; a write in the same cycle is seen by the following read only
  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    if (rdEn) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/oni_cfg_ctrl.sv
`timescale 1ns/1ps
module oni_cfg_ctrl
  import oni_cfg_pkg::*;
#(
  parameter int MODE_W    = 2,
  parameter int STEP_W    = 3,
  parameter int NUM_STEPS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [MODE_W-1:0]        mode,
  input  logic                     lastFlag,
  input  logic                     cntLast,
  output logic                     rdEn,
  output logic [MODE_W+STEP_W-1:0] rdAddr,
  output strobe_t                  strobes,
  output logic                     stepDone
);
  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(NUM_STEPS - 1);

  phase_t            phase;
  logic [STEP_W-1:0] stepIdx;
  logic [STEP_W-1:0] curStep;
  logic [MODE_W-1:0] lastMode;
  logic [STEP_W-1:0] effStep;
  logic              accept;
  logic              finish;

  assign accept  = start && (phase == PH_IDLE);
  assign effStep = (mode != lastMode) ? '0 : stepIdx;
  assign finish  = (phase == PH_RUN) && cntLast;
  assign rdEn    = accept;
  assign rdAddr  = {mode, effStep};

  always_comb begin
    strobes           = '0;
    strobes.loadOut   = (phase == PH_LOAD);
    strobes.countDown = (phase == PH_RUN);
    strobes.endStep   = finish;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      stepIdx  <= '0;
      curStep  <= '0;
      lastMode <= '0;
      stepDone <= 1'b0;
    end else begin
      stepDone <= finish;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_LOAD;
          lastMode <= mode;
          curStep  <= effStep;
        end
        PH_LOAD: phase <= PH_RUN;
        PH_RUN: if (cntLast) begin
          phase   <= PH_IDLE;
          stepIdx <= (lastFlag || curStep == LAST_IDX) ? '0 : curStep + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> !stepDone);

  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (start && phase != PH_IDLE) |=> ($stable(lastMode) && $stable(curStep)));

  a_r6_last_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && lastFlag) |-> (stepIdx == '0));

  a_r3_load_follows: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (phase == PH_LOAD));
endmodule

// File: rtl/oni_cfg_dp.sv
`timescale 1ns/1ps
module oni_cfg_dp
  import oni_cfg_pkg::*;
#(
  parameter int NUM_LASERS = 8,
  parameter int LVL_W      = 3,
  parameter int NUM_RINGS  = 8,
  parameter int DUR_W      = 16,
  parameter int MAX_LVL    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobes,
  input  logic [NUM_LASERS*LVL_W-1:0] entLaser,
  input  logic [NUM_RINGS-1:0]        entRing,
  input  logic [DUR_W-1:0]            entDur,
  output logic [NUM_LASERS*LVL_W-1:0] laserCtl,
  output logic [NUM_RINGS-1:0]        ringCtl,
  output logic                        cntLast
);
  localparam int               LAS_W = NUM_LASERS * LVL_W;
  localparam logic [LVL_W-1:0] CAP   = LVL_W'(MAX_LVL);

  logic [LAS_W-1:0] capped;
  logic [DUR_W-1:0] cnt;

  for (genvar i = 0; i < NUM_LASERS; i++) begin : g_cap
    assign capped[i*LVL_W +: LVL_W] =
      (entLaser[i*LVL_W +: LVL_W] > CAP) ? CAP : entLaser[i*LVL_W +: LVL_W];

    a_r8_level_cap: assert property (@(posedge clk) disable iff (!rstN)
      laserCtl[i*LVL_W +: LVL_W] <= CAP);
  end

  assign cntLast = (cnt == DUR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laserCtl <= '0;
      ringCtl  <= '0;
      cnt      <= '0;
    end else begin
      if (strobes.loadOut) begin
        laserCtl <= capped;
        ringCtl  <= entRing;
        cnt      <= (entDur == '0) ? DUR_W'(1) : entDur;
      end else if (strobes.countDown) begin
        cnt <= cnt - 1'b1;
      end
      if (strobes.endStep) laserCtl <= '0;
    end
  end

  a_r4_ring_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobes.endStep |=> $stable(ringCtl));

  a_r4_count_live: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countDown |-> (cnt != '0));
endmodule

// File: rtl/oni_cfg_manager.sv
`timescale 1ns/1ps
module oni_cfg_manager
  import oni_cfg_pkg::*;
#(
  parameter int NUM_MODES  = 4,
  parameter int NUM_STEPS  = 8,
  parameter int NUM_LASERS = 8,
  parameter int LVL_W      = 3,
  parameter int NUM_RINGS  = 8,
  parameter int DUR_W      = 16,
  parameter int MAX_LVL    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [$clog2(NUM_MODES)-1:0]   wrMode,
  input  logic [$clog2(NUM_STEPS)-1:0]   wrStep,
  input  logic [NUM_LASERS*LVL_W-1:0]    wrLaser,
  input  logic [NUM_RINGS-1:0]           wrRing,
  input  logic [DUR_W-1:0]               wrDur,
  input  logic                           wrLast,
  input  logic                           start,
  input  logic [$clog2(NUM_MODES)-1:0]   mode,
  output logic                           stepDone,
  output logic [NUM_LASERS*LVL_W-1:0]    laserCtl,
  output logic [NUM_RINGS-1:0]           ringCtl
);
  localparam int MODE_W  = $clog2(NUM_MODES);
  localparam int STEP_W  = $clog2(NUM_STEPS);
  localparam int ADDR_W  = MODE_W + STEP_W;
  localparam int LAS_W   = NUM_LASERS * LVL_W;
  localparam int RING_LO = LAS_W;
  localparam int DUR_LO  = RING_LO + NUM_RINGS;
  localparam int LAST_B  = DUR_LO + DUR_W;
  localparam int ENTRY_W = LAST_B + 1;

  logic [ENTRY_W-1:0] rdData;
  logic               rdEn;
  logic [ADDR_W-1:0]  rdAddr;
  logic               cntLast;
  strobe_t            strobes;

  oni_cfg_mem #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)) u_mem (
    .clk    (clk),
    .wrEn   (wrEn),
    .wrAddr ({wrMode, wrStep}),
    .wrData ({wrLast, wrDur, wrRing, wrLaser}),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  oni_cfg_ctrl #(.MODE_W(MODE_W), .STEP_W(STEP_W), .NUM_STEPS(NUM_STEPS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mode     (mode),
    .lastFlag (rdData[LAST_B]),
    .cntLast  (cntLast),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .strobes  (strobes),
    .stepDone (stepDone)
  );

  oni_cfg_dp #(
    .NUM_LASERS(NUM_LASERS), .LVL_W(LVL_W), .NUM_RINGS(NUM_RINGS),
    .DUR_W(DUR_W), .MAX_LVL(MAX_LVL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .entLaser (rdData[LAS_W-1:0]),
    .entRing  (rdData[DUR_LO-1:RING_LO]),
    .entDur   (rdData[LAST_B-1:DUR_LO]),
    .laserCtl (laserCtl),
    .ringCtl  (ringCtl),
    .cntLast  (cntLast)
  );

  a_r4_dark_at_done: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |-> (laserCtl == '0));
endmodule

// File: tb/test_oni_cfg_manager.sv
`timescale 1ns/1ps
module test_oni_cfg_manager;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrMode = '0;
  logic [2:0]  wrStep = '0;
  logic [23:0] wrLaser = '0;
  logic [7:0]  wrRing = '0;
  logic [15:0] wrDur = '0;
  logic        wrLast = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic        stepDone;
  logic [23:0] laserCtl;
  logic [7:0]  ringCtl;

  oni_cfg_manager i_oni_cfg_manager (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMode(wrMode), .wrStep(wrStep),
    .wrLaser(wrLaser), .wrRing(wrRing), .wrDur(wrDur), .wrLast(wrLast),
    .start(start), .mode(mode), .stepDone(stepDone),
    .laserCtl(laserCtl), .ringCtl(ringCtl)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int          startCyc;
    logic [23:0] laser;
    logic [7:0]  ring;
    int          dur;
  } exp_t;
  exp_t q[$];

  // Reference table and sequencing state
  logic [23:0] mLas [4][8];
  logic [7:0]  mRing[4][8];
  int          mDur [4][8];
  bit          mLast[4][8];
  int          idx = 0;
  int          lastMode = 0;

  function automatic logic [23:0] capCodes(logic [23:0] v);
    logic [23:0] r;
    for (int i = 0; i < 8; i++) r[3*i +: 3] = (v[3*i +: 3] > 3'd4) ? 3'd4 : v[3*i +: 3];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic writeEntry(int m, int s, logic [23:0] l, logic [7:0] r, int d, bit last);
    @(negedge clk);
    wrEn = 1'b1; wrMode = 2'(m); wrStep = 3'(s);
    wrLaser = l; wrRing = r; wrDur = 16'(d); wrLast = last;
    @(negedge clk);
    wrEn = 1'b0;
    mLas[m][s] = l; mRing[m][s] = r; mDur[m][s] = d; mLast[m][s] = last;
  endtask

  // Driver: issues a start, pushes the expected step, returns while stepDone is high
  task automatic runStep(int m, bit poke, bit collide, logic [23:0] cl, logic [7:0] cr);
    int st;
    exp_t e;
    st = (m != lastMode) ? 0 : idx;
    e.startCyc = cyc + 1;
    e.laser = capCodes(mLas[m][st]);
    e.ring = mRing[m][st];
    e.dur = (mDur[m][st] == 0) ? 1 : mDur[m][st];
    start = 1'b1; mode = 2'(m);
    if (collide) begin
      wrEn = 1'b1; wrMode = 2'(m); wrStep = 3'(st);
      wrLaser = cl; wrRing = cr; wrDur = 16'(mDur[m][st]); wrLast = mLast[m][st];
    end
    q.push_back(e);
    @(negedge clk);
    start = 1'b0; wrEn = 1'b0;
    if (collide) begin mLas[m][st] = cl; mRing[m][st] = cr; end
    lastMode = m;
    idx = (mLast[m][st] || st == 7) ? 0 : st + 1;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; mode = 2'((m + 1) % 4);
      @(negedge clk);
      start = 1'b0; mode = 2'(m);
    end
    while (!stepDone) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (q.size() == 0) begin
        check("R4 lasers dark between steps", 32'(laserCtl), 32'h0);
      end else begin
        exp_t e;
        e = q[0];
        if (cyc == e.startCyc + 1) begin
          check("R2 R3 R8 laser codes on load", 32'(laserCtl), 32'(e.laser));
          check("R2 R3 ring mask on load", 32'(ringCtl), 32'(e.ring));
        end else if (cyc > e.startCyc + 1 && cyc <= e.startCyc + e.dur) begin
          check("R4 R9 laser codes held", 32'(laserCtl), 32'(e.laser));
          check("R4 R9 ring mask held", 32'(ringCtl), 32'(e.ring));
          check("R5 no early stepDone", 32'(stepDone), 32'h0);
        end else if (cyc == e.startCyc + e.dur + 1) begin
          check("R4 lasers off at step end", 32'(laserCtl), 32'h0);
          check("R4 rings held at step end", 32'(ringCtl), 32'(e.ring));
          check("R5 stepDone high", 32'(stepDone), 32'h1);
        end else if (cyc == e.startCyc + e.dur + 2) begin
          check("R5 stepDone single cycle", 32'(stepDone), 32'h0);
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL R5 watchdog actual=hung expected=stepDone");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 laserCtl reset", 32'(laserCtl), 32'h0);
    check("R1 ringCtl reset", 32'(ringCtl), 32'h0);
    check("R1 stepDone reset", 32'(stepDone), 32'h0);

    writeEntry(0, 0, {3'd3,3'd2,3'd1,3'd0,3'd4,3'd3,3'd2,3'd1}, 8'hA5, 3, 1'b0);
    writeEntry(0, 1, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h3C, 0, 1'b0);
    writeEntry(0, 2, {8{3'd2}}, 8'hFF, 2, 1'b1);
    for (int s = 0; s < 8; s++) writeEntry(1, s, {8{3'(s)}}, 8'(s + 16), 1, 1'b0);
    writeEntry(2, 0, {8{3'd1}}, 8'h81, 6, 1'b0);
    writeEntry(2, 1, {8{3'd3}}, 8'h42, 2, 1'b0);
    writeEntry(3, 0, {8{3'd4}}, 8'h0F, 2, 1'b1);

    // R1 R6: step 0 of mode 0, then step 1 (zero duration, capped codes R8)
    runStep(0, 1'b0, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    runStep(0, 1'b0, 1'b0, '0, '0);
    // R9: start while stepDone is high, step 2 carries the last flag
    runStep(0, 1'b0, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    // R6: last flag sends mode 0 back to step 0
    runStep(0, 1'b0, 1'b0, '0, '0);
    repeat (2) @(negedge clk);
    // R7: mode change restarts at step 0, then R6 wrap after step 7
    for (int k = 0; k < 9; k++) runStep(1, 1'b0, 1'b0, '0, '0);
    repeat (2) @(negedge clk);
    // R9: start with another mode during a running step is ignored
    runStep(2, 1'b1, 1'b0, '0, '0);
    repeat (2) @(negedge clk);
    runStep(2, 1'b0, 1'b0, '0, '0);
    repeat (2) @(negedge clk);
    // R10: write and read of the same entry in one cycle
    runStep(3, 1'b0, 1'b1, {8{3'd1}}, 8'hE7);
    repeat (2) @(negedge clk);
    runStep(3, 1'b0, 1'b0, '0, '0);
    repeat (4) @(negedge clk);
    check("R5 R6 scoreboard drained", 32'(q.size()), 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule